// File: doc/BRIEF.md
# Timer capture/compare channel

This block is one capture/compare channel that sits beside an external 16-bit timer counter. The counter is built elsewhere. The channel receives the counter value and its status flags: count direction, up-down mode, counter at zero, and a match pulse from channel 0. From these it does one of two jobs, chosen by a mode bit. In capture mode it stores the counter value when a selected event occurs. In compare mode it drives an output pin according to one of seven compare actions.

Software reaches the channel through a byte-wide register port with four addresses:

| Address | Contents |
|---|---|
| 0 | Control register |
| 1 | Low byte of the 16-bit value |
| 2 | High byte of the 16-bit value |
| 3 | Status; bit 0 is the event flag |

Writes take effect on the clock edge on which `wr_i` is high. Reads are combinational.

Writes to the 16-bit value go in byte by byte. The low byte waits in a holding buffer. In compare mode the whole new value is applied only when the counter next reads zero, so the compare value never changes partway through a count period. A sticky event flag, gated by an enable bit, drives the interrupt request.

Top module: `cc_channel`

## Requirements
- R1: After reset, the control register (address 0) reads 0x40, the value (addresses 1 and 2) reads 0x0000, the status register (address 3) reads 0, and `cmp_o` and `irq_o` are low.
- R2: The control register fields are: bit 7 selects the capture source, bit 6 is the interrupt enable, bits 5:3 are the compare action, bit 2 is the mode (1 = compare) and bits 1:0 are the edge select. The pin passes through a two-stage synchronizer. In capture mode, edge select 00 captures nothing, 01 captures on rising pin edges, 10 on falling edges and 11 on both. The value stored is the counter value present on the third rising clock edge after the pin changes.
- R3: With control bit 7 set and a nonzero edge select, the channel captures the counter value on every clock edge at which `alt_evt_i` is high, and pin edges cause no capture.
- R4: A write to address 1 only loads a holding buffer and leaves the readable value unchanged. In capture mode, a write to address 2 loads the value at once with {written byte, buffered byte}.
- R5: In compare mode, a write to address 2 leaves the value unchanged. The pending {high, low} value is applied at the first later clock edge at which `cnt_i` equals 0x0000.
- R6: In compare mode, a match (`cnt_i` equal to the value) sets `cmp_o` with action 000, clears it with action 001 and toggles it with action 010, one edge after the match.
- R7: Action 011 with `updown_i`=1 sets `cmp_o` on a match while `cnt_down_i`=0 and clears it on a match while `cnt_down_i`=1. With `updown_i`=0 it sets `cmp_o` on a match and clears it when `cnt_zero_i` is high. Action 100 does the mirror of each of these. A match has priority over the zero event.
- R8: Action 101 clears `cmp_o` on `ch0_match_i` and sets it on its own match. Action 110 sets `cmp_o` on `ch0_match_i` and clears it on its own match. The channel's own match has priority over the channel-0 match.
- R9: Writing a control byte whose bits 5:3 are 111 drives `cmp_o` low on that edge. The stored action field keeps its previous value, and the other fields take the written bits.
- R10: A capture or a compare match sets the status flag. A write to address 3 with bit 0 set clears the flag; if a new event arrives on the same edge, the set wins. `irq_o` is high exactly when both the flag and the interrupt enable bit are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Timer counter value |
| cnt_down_i | input | 1 | Counter is counting down |
| updown_i | input | 1 | Counter runs in up-down mode |
| cnt_zero_i | input | 1 | Counter is at zero |
| ch0_match_i | input | 1 | Channel 0 compare match |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| alt_evt_i | input | 1 | Alternate capture event strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |
| cmp_o | output | 1 | Compare output pin |
| irq_o | output | 1 | Interrupt request |

## Verification
Register writes show up one edge after the write strobe, and reads are combinational. The bench therefore drives each write on a falling edge and reads the result on the next falling edge. A compare match, a zero event or a channel-0 event changes `cmp_o` and the flag one edge later. A pin change is captured on the third edge after it and takes the counter value present at that edge; the bench advances the counter every cycle so that a capture one cycle early or late reads back a wrong value. The random phase drives new inputs after each falling edge, updates the expected output with a bench function, and compares on the next falling edge.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    ACT_SET     = 3'b000,
    ACT_CLR     = 3'b001,
    ACT_TGL     = 3'b010,
    ACT_SET_UP  = 3'b011,
    ACT_CLR_UP  = 3'b100,
    ACT_CH0_CLR = 3'b101,
    ACT_CH0_SET = 3'b110,
    ACT_INIT    = 3'b111
  } act_e;

  typedef struct packed {
    logic       alt_src;
    logic       irq_en;
    act_e       act;
    logic       cmp_mode;
    logic [1:0] edge_sel;
  } ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_VLO  = 2'd1;
  localparam logic [1:0] A_VHI  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam logic [7:0] CTRL_RST = 8'h40;
endpackage

// File: rtl/cc_sync_edge.sv
module cc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its delayed copy
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];

  a_r2_edge_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
endmodule

// File: rtl/cc_value_reg.sv
module cc_value_reg #(
  parameter int CW = 16,
  localparam int HW = CW / 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [HW-1:0] wdata_i,
  input  logic          cmp_mode_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          cap_i,
  output logic [CW-1:0] val_o
);
  logic [HW-1:0] lo_buf_q;
  logic [CW-1:0] val_q, pend_q;
  logic          pend_vld_q;
  logic          at_zero, apply;

  assign at_zero = (cnt_i == '0);
  assign apply   = pend_vld_q && at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_buf_q   <= '0;
      val_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      if (wr_lo_i) lo_buf_q <= wdata_i;
      // capture has priority over a software write in the same cycle
      if (cap_i)                      val_q <= cnt_i;
      else if (wr_hi_i && !cmp_mode_i) val_q <= {wdata_i, lo_buf_q};
      else if (apply)                  val_q <= pend_q;
      if (wr_hi_i && cmp_mode_i) begin
        pend_q     <= {wdata_i, lo_buf_q};
        pend_vld_q <= 1'b1;
      end else if (apply) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign val_o = val_q;

  a_r2_cap_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cap_i) |-> val_q == $past(cnt_i));
  a_r5_deferred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmp_mode_i) && $past(cnt_i) != '0 && !$past(cap_i)) |-> $stable(val_q));
  a_r4_lo_buffered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_lo_i) && !$past(cap_i) && $past(cnt_i) != '0) |-> $stable(val_q));
endmodule

// File: rtl/cc_cmp_out.sv
module cc_cmp_out
  import cc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  act_e act_i,
  input  logic match_i,
  input  logic down_i,
  input  logic updown_i,
  input  logic zero_i,
  input  logic ch0_i,
  input  logic force_i,
  output logic out_o
);
  logic out_q, out_d;

  always_comb begin
    out_d = out_q;
    if (force_i) begin
      out_d = 1'b0;
    end else if (en_i) begin
      unique case (act_i)
        ACT_SET: if (match_i) out_d = 1'b1;
        ACT_CLR: if (match_i) out_d = 1'b0;
        ACT_TGL: if (match_i) out_d = ~out_q;
        ACT_SET_UP: begin
          if (match_i)     out_d = updown_i ? ~down_i : 1'b1;
          else if (zero_i && !updown_i) out_d = 1'b0;
        end
        ACT_CLR_UP: begin
          if (match_i)     out_d = updown_i ? down_i : 1'b0;
          else if (zero_i && !updown_i) out_d = 1'b1;
        end
        ACT_CH0_CLR: begin
          if (match_i)    out_d = 1'b1;
          else if (ch0_i) out_d = 1'b0;
        end
        ACT_CH0_SET: begin
          if (match_i)    out_d = 1'b0;
          else if (ch0_i) out_d = 1'b1;
        end
        default: out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= out_d;
  end

  assign out_o = out_q;

  a_r9_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(force_i) |-> !out_o);
  a_r6_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && act_i == ACT_TGL && match_i && !force_i) |-> out_o != $past(out_o));
  a_r7_updown_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && act_i == ACT_SET_UP && updown_i && match_i && !down_i && !force_i) |-> out_o);
  a_r8_own_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i && act_i == ACT_CH0_SET && match_i && !force_i) |-> !out_o);
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i && !force_i) |-> $stable(out_o));
endmodule

// File: rtl/cc_channel.sv
module cc_channel
  import cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int BYTE_W     = CNT_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              cnt_down_i,
  input  logic              updown_i,
  input  logic              cnt_zero_i,
  input  logic              ch0_match_i,
  input  logic              cap_pin_i,
  input  logic              alt_evt_i,
  input  logic              wr_i,
  input  logic [1:0]        addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              cmp_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  ctrl_t             ctrl_w;
  logic              flag_q;
  logic [CNT_W-1:0]  val;
  logic              pin_rise, pin_fall;
  logic              wr_ctrl, wr_lo, wr_hi, flag_clr, force_init;
  logic              pin_evt, src_evt, cap, match;

  assign ctrl_w     = ctrl_t'(wdata_i[7:0]);
  assign wr_ctrl    = wr_i && addr_i == A_CTRL;
  assign wr_lo      = wr_i && addr_i == A_VLO;
  assign wr_hi      = wr_i && addr_i == A_VHI;
  assign flag_clr   = wr_i && addr_i == A_STAT && wdata_i[0];
  assign force_init = wr_ctrl && ctrl_w.act == ACT_INIT;

  cc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cap_pin_i),
    .rise_o(pin_rise),
    .fall_o(pin_fall)
  );

  assign pin_evt = (ctrl_q.edge_sel[0] && pin_rise) || (ctrl_q.edge_sel[1] && pin_fall);
  assign src_evt = ctrl_q.alt_src ? (alt_evt_i && ctrl_q.edge_sel != 2'b00) : pin_evt;
  assign cap     = !ctrl_q.cmp_mode && src_evt;
  assign match   = ctrl_q.cmp_mode && cnt_i == val;

  cc_value_reg #(.CW(CNT_W)) u_val (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_hi),
    .wdata_i   (wdata_i),
    .cmp_mode_i(ctrl_q.cmp_mode),
    .cnt_i     (cnt_i),
    .cap_i     (cap),
    .val_o     (val)
  );

  cc_cmp_out u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ctrl_q.cmp_mode),
    .act_i   (ctrl_q.act),
    .match_i (match),
    .down_i  (cnt_down_i),
    .updown_i(updown_i),
    .zero_i  (cnt_zero_i),
    .ch0_i   (ch0_match_i),
    .force_i (force_init),
    .out_o   (cmp_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= ctrl_t'(CTRL_RST);
      flag_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q <= ctrl_w;
        if (force_init) ctrl_q.act <= ctrl_q.act;  // init command leaves the action field alone
      end
      if (cap || match)  flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = BYTE_W'(ctrl_q);
      A_VLO:   rdata_o = val[BYTE_W-1:0];
      A_VHI:   rdata_o = val[CNT_W-1:BYTE_W];
      default: rdata_o = BYTE_W'(flag_q);
    endcase
  end

  assign irq_o = flag_q && ctrl_q.irq_en;

  a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flag_q) && !$past(flag_clr)) |-> flag_q);
  a_r10_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cap || match) |-> flag_q);
  a_r9_act_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(force_init) |-> ctrl_q.act == $past(ctrl_q.act));
  a_r10_irq_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.irq_en |-> !irq_o);
endmodule

// File: tb/cc_channel_tb_top.sv
`timescale 1ns/1ps
module cc_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h0011;
  logic        cdown = 1'b0, udm = 1'b0, ch0 = 1'b0, pin = 1'b0, alt = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        cmp, irq, czero;
  int          checks = 0, failures = 0;

  assign czero = (cnt == 16'h0000);

  always #10 clk = ~clk;

  cc_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_down_i(cdown), .updown_i(udm),
    .cnt_zero_i(czero), .ch0_match_i(ch0), .cap_pin_i(pin), .alt_evt_i(alt),
    .wr_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cmp_o(cmp), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    step();
    wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic rval(output logic [15:0] v);
    logic [7:0] lo, hi;
    rreg(2'd1, lo); rreg(2'd2, hi);
    v = {hi, lo};
  endtask

  // pin change, counter advancing each cycle; capture takes base+2
  task automatic drive_pin(input logic v, input logic [15:0] base);
    pin = v; cnt = base;
    for (int i = 1; i <= 3; i++) begin
      step(); cnt = base + 16'(i);
    end
    step();
  endtask

  function automatic logic ref_out(input logic [2:0] act, input logic o, input logic m,
                                   input logic dn, input logic ud, input logic z, input logic c0);
    logic r = o;
    case (act)
      3'd0: if (m) r = 1'b1;
      3'd1: if (m) r = 1'b0;
      3'd2: if (m) r = ~o;
      3'd3: if (m) r = ud ? ~dn : 1'b1; else if (z && !ud) r = 1'b0;
      3'd4: if (m) r = ud ? dn : 1'b0;  else if (z && !ud) r = 1'b1;
      3'd5: if (m) r = 1'b1; else if (c0) r = 1'b0;
      3'd6: if (m) r = 1'b0; else if (c0) r = 1'b1;
      default: r = o;
    endcase
    return r;
  endfunction

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] v;
    logic        exp_o;
    void'($urandom(32'h1234_5678));
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1
    rreg(2'd0, d); chk("R1 ctrl", 16'(d), 16'h0040);
    rval(v);       chk("R1 value", v, 16'h0000);
    rreg(2'd3, d); chk("R1 status", 16'(d), 16'h0000);
    chk("R1 cmp/irq", {14'd0, cmp, irq}, 16'h0000);

    // R2 edge selection
    wreg(2'd0, 8'h01);
    drive_pin(1'b1, 16'h0100); rval(v); chk("R2 rise", v, 16'h0102);
    drive_pin(1'b0, 16'h0200); rval(v); chk("R2 fall ignored", v, 16'h0102);
    wreg(2'd0, 8'h02);
    drive_pin(1'b1, 16'h0300); rval(v); chk("R2 rise ignored", v, 16'h0102);
    drive_pin(1'b0, 16'h0400); rval(v); chk("R2 fall", v, 16'h0402);
    wreg(2'd0, 8'h03);
    drive_pin(1'b1, 16'h0500); rval(v); chk("R2 both rise", v, 16'h0502);
    drive_pin(1'b0, 16'h0600); rval(v); chk("R2 both fall", v, 16'h0602);
    wreg(2'd0, 8'h00);
    drive_pin(1'b1, 16'h0700); rval(v); chk("R2 sel00", v, 16'h0602);

    // R10 flag and mask
    rreg(2'd3, d); chk("R10 flag set", 16'(d), 16'h0001);
    chk("R10 irq masked", 16'(irq), 16'h0000);
    wreg(2'd0, 8'h41); chk("R10 irq on", 16'(irq), 16'h0001);
    wreg(2'd3, 8'h01);
    rreg(2'd3, d); chk("R10 flag clr", 16'(d), 16'h0000);
    chk("R10 irq off", 16'(irq), 16'h0000);

    // R3 alternate source
    wreg(2'd0, 8'h83);
    drive_pin(1'b0, 16'h0800); rval(v); chk("R3 pin ignored", v, 16'h0602);
    alt = 1'b1; cnt = 16'h0900; step(); alt = 1'b0; cnt = 16'h0901; step();
    rval(v); chk("R3 strobe", v, 16'h0900);

    // R4 byte buffering in capture mode
    wreg(2'd0, 8'h40);
    wreg(2'd1, 8'h55); rval(v); chk("R4 low buffered", v, 16'h0900);
    wreg(2'd2, 8'hAA); rval(v); chk("R4 high immediate", v, 16'hAA55);

    // R5 deferred update in compare mode
    cnt = 16'h0005;
    wreg(2'd0, 8'h44);
    wreg(2'd1, 8'h10); wreg(2'd2, 8'h00);
    step(); rval(v); chk("R5 held", v, 16'hAA55);
    cnt = 16'h0000; step(); cnt = 16'h0011;
    rval(v); chk("R5 applied", v, 16'h0010);
    wreg(2'd3, 8'h01);

    // R6 set / clear / toggle
    chk("R6 out idle", 16'(cmp), 16'h0000);
    cnt = 16'h0010; step(); cnt = 16'h0011;
    chk("R6 set", 16'(cmp), 16'h0001);
    rreg(2'd3, d); chk("R10 match flag", 16'(d), 16'h0001);
    wreg(2'd0, 8'h4C);
    cnt = 16'h0010; step(); cnt = 16'h0011;
    chk("R6 clear", 16'(cmp), 16'h0000);
    wreg(2'd0, 8'h54);
    cnt = 16'h0010; step(); chk("R6 toggle1", 16'(cmp), 16'h0001);
    step(); chk("R6 toggle2", 16'(cmp), 16'h0000);
    step(); cnt = 16'h0011; chk("R6 toggle3", 16'(cmp), 16'h0001);

    // R9 init command
    wreg(2'd0, 8'h7C);
    chk("R9 forced low", 16'(cmp), 16'h0000);
    rreg(2'd0, d); chk("R9 act kept", 16'(d), 16'h0054);

    // R6 R7 R8 random compare traffic
    for (int a = 0; a < 7; a++) begin
      string tag;
      tag = (a < 3) ? "R6 rand" : (a < 5) ? "R7 rand" : "R8 rand";
      ch0 = 1'b0; cnt = 16'h0011;
      wreg(2'd0, 8'h44 | 8'(a << 3));
      wreg(2'd0, 8'h7C);
      exp_o = 1'b0;
      chk(tag, 16'(cmp), 16'(exp_o));
      for (int k = 0; k < 200; k++) begin
        int sel;
        sel = int'($urandom_range(0, 4));
        case (sel)
          0: cnt = 16'h0000;
          1: cnt = 16'h0010;
          2: cnt = 16'h000F;
          3: cnt = 16'h0011;
          default: cnt = 16'($urandom_range(16'h0020, 16'hFFFF));
        endcase
        cdown = 1'($urandom_range(0, 1));
        udm   = 1'($urandom_range(0, 1));
        ch0   = 1'($urandom_range(0, 1));
        #1;
        exp_o = ref_out(3'(a), exp_o, cnt == 16'h0010, cdown, udm, czero, ch0);
        step();
        chk(tag, 16'(cmp), 16'(exp_o));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule